// File: doc/BRIEF.md
# Sector scan comparator

This block carries out the three scan commands of a floppy disk controller. A scan command arrives as a run of nine command bytes. The first byte is the opcode, and its low five bits select the comparison rule. Once the command has started, every byte read from the disk sector, tagged with its slot index inside the sector, is compared against a reference byte that the host supplies for the same position. The block keeps the two status-2 bits that describe the outcome of the sector: scan hit and scan not satisfied.

A sector counts as satisfying the scan when the not-satisfied bit is still clear after its last byte has been compared. The scan then finishes, the block raises a one-cycle terminate pulse that acts as a terminal count, and any further disk bytes are accepted and thrown away without comparison. If the drive is not ready when the command completes, the block reports the not-ready and abnormal-termination bits of status 0, clears the status-2 bits and reports completion at once, with no data phase.

A disk byte is taken only when its host reference byte is present. While the reference byte is missing, the comparison stalls.

Top module: `sector_scan_cmp`

## Requirements
- R1: The low five bits of the first command byte select the mode: 0x11 is equal, 0x19 is low-or-equal and 0x1D is high-or-equal. Bits 7..5 are ignored. A first byte with any other low five bits is dropped and does not begin a command.
- R2: A scan begins only on the ninth command byte, and `scanBusy` rises in the cycle after that byte. Before that, disk bytes are not acknowledged.
- R3: A compared byte at slot 0 first sets `scanHit` and clears `scanNotSat`. An equal byte at slot 0 therefore leaves hit=1 and not-satisfied=0.
- R4: Any compared byte that differs from its reference clears `scanHit` and sets `scanNotSat`. Equal bytes later in the sector do not undo this. The two bits are never both 1.
- R5: In low-or-equal mode, a disk byte below its reference clears `scanNotSat` again. In high-or-equal mode, a disk byte above its reference clears it again. `scanHit` stays 0 in both cases.
- R6: When the byte at slot `secSize`-1 is compared and leaves `scanNotSat` clear, `scanDone` goes to 1 and `termPulse` is high for exactly one cycle. Both show in the cycle after that byte.
- R7: After `scanDone`, every valid disk byte is acknowledged without a host byte, `hostAck` stays 0, and `scanHit`/`scanNotSat` keep their values.
- R8: If `driveReady` is 0 with the ninth command byte, then in the next cycle `st0NotReady`=1, `st0Fail`=1, `scanHit`=0, `scanNotSat`=0, `scanBusy`=0 and `cmdDone` pulses for one cycle. A ready start clears the two status-0 bits.
- R9: While scanning and not done, a disk byte without `hostValid` is not acknowledged, and the status bits are unchanged.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command byte; the first byte is the opcode |
| driveReady | input | 1 | Ready state of the selected drive |
| secSize | input | SLOT_W | Sector size in bytes |
| diskValid | input | 1 | A disk byte is offered |
| diskByte | input | DATA_W | Disk data byte |
| diskSlot | input | SLOT_W | Byte position in the sector, 0 for the first byte |
| hostValid | input | 1 | A host reference byte is offered |
| hostByte | input | DATA_W | Host reference byte |
| diskAck | output | 1 | Disk byte taken this cycle (combinational) |
| hostAck | output | 1 | Host byte taken and compared this cycle (combinational) |
| scanBusy | output | 1 | A scan command is active |
| scanHit | output | 1 | Status 2 scan-hit bit |
| scanNotSat | output | 1 | Status 2 scan-not-satisfied bit |
| scanDone | output | 1 | A sector has satisfied the scan |
| termPulse | output | 1 | One-cycle terminate request |
| st0NotReady | output | 1 | Status 0 not-ready bit |
| st0Fail | output | 1 | Status 0 abnormal-termination bit |
| cmdDone | output | 1 | One-cycle pulse on a not-ready completion |

## Verification
The acknowledge outputs are combinational, so the bench samples them 1 ns after it drives a byte at the falling edge, before the clock edge that takes the byte. Status bits, `scanDone`, `termPulse`, `scanBusy` and the status-0 bits are registered once. The bench therefore checks them at the falling edge that follows the rising edge on which the byte or the ninth command byte was taken. It checks the one-cycle pulses again one cycle later, to confirm that they have dropped.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    MODE_EQ = 2'd0,
    MODE_LE = 2'd1,
    MODE_GE = 2'd2
  } scanMode_t;

  typedef struct packed {
    logic      clrStat;
    logic      setNotReady;
    logic      cmpEn;
    scanMode_t mode;
  } dpStrobe_t;

  localparam logic [4:0] OP_EQ = 5'h11;
  localparam logic [4:0] OP_LE = 5'h19;
  localparam logic [4:0] OP_GE = 5'h1D;

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int CMD_LEN = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  logic       driveReady,
  input  logic       diskValid,
  input  logic       hostValid,
  input  logic       sectorOk,
  output dpStrobe_t  strobe,
  output logic       diskAck,
  output logic       hostAck,
  output logic       scanBusy,
  output logic       scanDone,
  output logic       termPulse,
  output logic       cmdDone
);

  localparam int CNT_W = $clog2(CMD_LEN);

  logic [CNT_W-1:0] cmdCnt;
  scanMode_t        modeQ;
  scanMode_t        opMode;
  logic             isScanOp;
  logic             startNow;
  logic             busyQ, doneQ, termQ, cmdDoneQ;

  always_comb begin
    isScanOp = 1'b1;
    opMode   = MODE_EQ;
    case (cmdByte[4:0])
      OP_EQ:   opMode = MODE_EQ;
      OP_LE:   opMode = MODE_LE;
      OP_GE:   opMode = MODE_GE;
      default: isScanOp = 1'b0;
    endcase
  end

  assign startNow = cmdValid && (cmdCnt == CNT_W'(CMD_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdCnt <= '0;
      modeQ  <= MODE_EQ;
    end else if (cmdValid) begin
      if (cmdCnt == '0) begin
        if (isScanOp) begin
          cmdCnt <= CNT_W'(1);
          modeQ  <= opMode;
        end
      end else if (startNow) begin
        cmdCnt <= '0;
      end else begin
        cmdCnt <= cmdCnt + CNT_W'(1);
      end
    end
  end

  assign diskAck = busyQ && diskValid && (doneQ || hostValid);
  assign hostAck = busyQ && !doneQ && diskValid && hostValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
      termQ    <= 1'b0;
      cmdDoneQ <= 1'b0;
    end else begin
      termQ    <= 1'b0;
      cmdDoneQ <= 1'b0;
      if (startNow) begin
        busyQ    <= driveReady;
        doneQ    <= 1'b0;
        cmdDoneQ <= !driveReady;
      end else if (hostAck && sectorOk) begin
        doneQ <= 1'b1;
        termQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.clrStat     = startNow;
    strobe.setNotReady = startNow && !driveReady;
    strobe.cmpEn       = hostAck && !startNow;
    strobe.mode        = modeQ;
  end

  assign scanBusy  = busyQ;
  assign scanDone  = doneQ;
  assign termPulse = termQ;
  assign cmdDone   = cmdDoneQ;

  AST_TERM_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    termQ |=> !termQ); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !startNow) |=> doneQ); // R7
  AST_NR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdDoneQ |-> !busyQ); // R8
  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> (!diskAck && !hostAck)); // R2
  AST_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !doneQ && !hostValid) |-> !diskAck); // R9

endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import scan_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] diskByte,
  input  logic [DATA_W-1:0] hostByte,
  input  logic [SLOT_W-1:0] diskSlot,
  input  logic [SLOT_W-1:0] secSize,
  output logic              scanHit,
  output logic              scanNotSat,
  output logic              st0NotReady,
  output logic              st0Fail,
  output logic              sectorOk
);

  logic hitQ, nsQ, nrQ, failQ;
  logic nextHit, nextNs;
  logic firstSlot, lastSlot, differ, lowOk, highOk;

  assign firstSlot = (diskSlot == '0);
  assign lastSlot  = (diskSlot == (secSize - SLOT_W'(1)));
  assign differ    = (diskByte != hostByte);
  assign lowOk     = (strobe.mode == MODE_LE) && (diskByte < hostByte);
  assign highOk    = (strobe.mode == MODE_GE) && (diskByte > hostByte);

  always_comb begin
    nextHit = firstSlot ? 1'b1 : hitQ;
    nextNs  = firstSlot ? 1'b0 : nsQ;
    if (differ) begin
      nextHit = 1'b0;
      nextNs  = !(lowOk || highOk);
    end
  end

  assign sectorOk = strobe.cmpEn && lastSlot && !nextNs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ  <= 1'b0;
      nsQ   <= 1'b0;
      nrQ   <= 1'b0;
      failQ <= 1'b0;
    end else if (strobe.clrStat) begin
      hitQ  <= 1'b0;
      nsQ   <= 1'b0;
      nrQ   <= strobe.setNotReady;
      failQ <= strobe.setNotReady;
    end else if (strobe.cmpEn) begin
      hitQ <= nextHit;
      nsQ  <= nextNs;
    end
  end

  assign scanHit     = hitQ;
  assign scanNotSat  = nsQ;
  assign st0NotReady = nrQ;
  assign st0Fail     = failQ;

  AST_HIT_NS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(hitQ && nsQ)); // R4
  AST_NR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    nrQ |-> (failQ && !hitQ && !nsQ)); // R8
  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmpEn && firstSlot && !differ) |=> (hitQ && !nsQ)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cmpEn && !strobe.clrStat) |=> ($stable(hitQ) && $stable(nsQ))); // R9

endmodule

// File: rtl/sector_scan_cmp.sv
module sector_scan_cmp
  import scan_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SLOT_W  = 11,
  parameter int CMD_LEN = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdByte,
  input  logic              driveReady,
  input  logic [SLOT_W-1:0] secSize,
  input  logic              diskValid,
  input  logic [DATA_W-1:0] diskByte,
  input  logic [SLOT_W-1:0] diskSlot,
  input  logic              hostValid,
  input  logic [DATA_W-1:0] hostByte,
  output logic              diskAck,
  output logic              hostAck,
  output logic              scanBusy,
  output logic              scanHit,
  output logic              scanNotSat,
  output logic              scanDone,
  output logic              termPulse,
  output logic              st0NotReady,
  output logic              st0Fail,
  output logic              cmdDone
);

  dpStrobe_t strobe;
  logic      sectorOk;

  scan_ctrl #(.CMD_LEN(CMD_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .driveReady(driveReady), .diskValid(diskValid), .hostValid(hostValid),
    .sectorOk(sectorOk), .strobe(strobe), .diskAck(diskAck), .hostAck(hostAck),
    .scanBusy(scanBusy), .scanDone(scanDone), .termPulse(termPulse),
    .cmdDone(cmdDone)
  );

  scan_dp #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .diskByte(diskByte),
    .hostByte(hostByte), .diskSlot(diskSlot), .secSize(secSize),
    .scanHit(scanHit), .scanNotSat(scanNotSat), .st0NotReady(st0NotReady),
    .st0Fail(st0Fail), .sectorOk(sectorOk)
  );

endmodule

// File: tb/tb_sector_scan_cmp.sv
`timescale 1ns/1ps
module tb_sector_scan_cmp;

  localparam int DATA_W = 8;
  localparam int SLOT_W = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdByte = '0;
  logic driveReady = 1'b1;
  logic [SLOT_W-1:0] secSize = SLOT_W'(4);
  logic diskValid = 1'b0;
  logic [DATA_W-1:0] diskByte = '0;
  logic [SLOT_W-1:0] diskSlot = '0;
  logic hostValid = 1'b0;
  logic [DATA_W-1:0] hostByte = '0;
  logic diskAck, hostAck, scanBusy, scanHit, scanNotSat, scanDone, termPulse;
  logic st0NotReady, st0Fail, cmdDone;

  always #5 clk = ~clk;

  sector_scan_cmp dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .driveReady(driveReady), .secSize(secSize), .diskValid(diskValid),
    .diskByte(diskByte), .diskSlot(diskSlot), .hostValid(hostValid),
    .hostByte(hostByte), .diskAck(diskAck), .hostAck(hostAck),
    .scanBusy(scanBusy), .scanHit(scanHit), .scanNotSat(scanNotSat),
    .scanDone(scanDone), .termPulse(termPulse), .st0NotReady(st0NotReady),
    .st0Fail(st0Fail), .cmdDone(cmdDone)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  bit mBusy = 0, mDone = 0, mHit = 0, mNs = 0, mNr = 0, mTerm = 0, mCmdDone = 0;
  int mMode = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req);
    chk({req, " busy"}, int'(scanBusy), int'(mBusy));
    chk({req, " hit"}, int'(scanHit), int'(mHit));
    chk({req, " notSat"}, int'(scanNotSat), int'(mNs));
    chk({req, " done"}, int'(scanDone), int'(mDone));
    chk({req, " term"}, int'(termPulse), int'(mTerm));
    chk({req, " nr"}, int'(st0NotReady), int'(mNr));
    chk({req, " fail"}, int'(st0Fail), int'(mNr));
    chk({req, " cmdDone"}, int'(cmdDone), int'(mCmdDone));
  endtask

  function automatic int modeOf(input logic [7:0] op);
    case (op[4:0])
      5'h11: return 0;
      5'h19: return 1;
      5'h1D: return 2;
      default: return -1;
    endcase
  endfunction

  // Sends nBytes command bytes; the payload bytes are 0 so that they never decode as opcodes.
  task automatic sendCmd(input logic [7:0] op, input bit rdy, input int nBytes, input string req);
    for (int i = 0; i < nBytes; i++) begin
      @(negedge clk);
      cmdValid = 1'b1;
      cmdByte = (i == 0) ? op : 8'h00;
      driveReady = rdy;
    end
    @(negedge clk);
    cmdValid = 1'b0;
    mTerm = 0;
    mCmdDone = 0;
    if (nBytes == 9 && modeOf(op) >= 0) begin
      mMode = modeOf(op);
      mBusy = rdy;
      mDone = 0;
      mHit = 0;
      mNs = 0;
      mNr = !rdy;
      mCmdDone = !rdy;
    end
    #1;
    checkOut(req);
  endtask

  task automatic feed(input int slot, input logic [7:0] d, input logic [7:0] h, input bit hv,
                      input string req);
    bit expD, expH, bh, bn;
    @(negedge clk);
    diskValid = 1'b1;
    diskSlot = SLOT_W'(slot);
    diskByte = d;
    hostByte = h;
    hostValid = hv;
    #1;
    expD = mBusy && (mDone || hv);
    expH = mBusy && !mDone && hv;
    chk({req, " diskAck"}, int'(diskAck), int'(expD));
    chk({req, " hostAck"}, int'(hostAck), int'(expH));
    mTerm = 0;
    mCmdDone = 0;
    if (expH) begin
      bh = (slot == 0) ? 1'b1 : mHit;
      bn = (slot == 0) ? 1'b0 : mNs;
      if (d != h) begin
        bh = 0;
        bn = 1;
        if (mMode == 1 && d < h) bn = 0;
        if (mMode == 2 && d > h) bn = 0;
      end
      mHit = bh;
      mNs = bn;
      if (slot == int'(secSize) - 1 && !bn) begin
        mDone = 1;
        mTerm = 1;
      end
    end
    @(negedge clk);
    diskValid = 1'b0;
    hostValid = 1'b0;
    #1;
    checkOut(req);
  endtask

  task automatic idleCycle(input string req);
    @(negedge clk);
    mTerm = 0;
    mCmdDone = 0;
    #1;
    checkOut(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] opList [3];
    void'($urandom(32'd1234));
    opList[0] = 8'h11; opList[1] = 8'h19; opList[2] = 8'h1D;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checkOut("R10 reset");

    // R1: a non-scan opcode never starts a command
    sendCmd(8'h03, 1, 9, "R1 ignored opcode");
    // R2: eight bytes are not enough
    sendCmd(8'h11, 1, 8, "R2 partial command");
    feed(0, 8'h55, 8'h55, 1, "R2 no ack before start");
    // the counter still waits for the ninth byte: one more byte starts the scan
    @(negedge clk); cmdValid = 1'b1; cmdByte = 8'h00;
    @(negedge clk); cmdValid = 1'b0;
    mBusy = 1; mMode = 0; mDone = 0; mHit = 0; mNs = 0; mNr = 0; mTerm = 0; mCmdDone = 0;
    #1; checkOut("R2 ninth byte starts");

    // R3/R6: an equal sector of 4 bytes, upper opcode bits set (R1)
    secSize = SLOT_W'(4);
    sendCmd(8'hF1, 1, 9, "R1 upper bits ignored");
    feed(0, 8'h10, 8'h10, 1, "R3 first slot");
    feed(1, 8'h20, 8'h20, 1, "R3 equal byte");
    feed(2, 8'h30, 8'h30, 0, "R9 stall");
    feed(2, 8'h30, 8'h30, 1, "R3 equal byte");
    feed(3, 8'h40, 8'h40, 1, "R6 last slot done");
    idleCycle("R6 term drops");
    feed(0, 8'h99, 8'h00, 0, "R7 byte after done");
    feed(1, 8'h01, 8'hFF, 1, "R7 no compare after done");

    // R4: a mismatch in equal mode is not undone by later equal bytes
    sendCmd(8'h11, 1, 9, "R4 restart");
    feed(0, 8'h10, 8'h10, 1, "R4 first");
    feed(1, 8'h11, 8'h10, 1, "R4 mismatch");
    feed(2, 8'h30, 8'h30, 1, "R4 stays");
    feed(3, 8'h40, 8'h40, 1, "R4 no done");

    // R5: low mode
    sendCmd(8'h19, 1, 9, "R5 low start");
    feed(0, 8'h05, 8'h10, 1, "R5 low smaller");
    feed(1, 8'h20, 8'h20, 1, "R5 low equal");
    feed(2, 8'h01, 8'h02, 1, "R5 low smaller");
    feed(3, 8'h00, 8'h80, 1, "R5 low done");
    // R5: high mode, a smaller byte fails it
    sendCmd(8'h1D, 1, 9, "R5 high start");
    feed(0, 8'h90, 8'h10, 1, "R5 high larger");
    feed(1, 8'h05, 8'h06, 1, "R5 high smaller");
    feed(2, 8'hFF, 8'h00, 1, "R5 high larger clears");
    feed(3, 8'h07, 8'h07, 1, "R5 high done");

    // R8: drive not ready
    sendCmd(8'h11, 0, 9, "R8 not ready");
    idleCycle("R8 cmdDone drops");
    feed(0, 8'h10, 8'h10, 1, "R8 no data phase");
    sendCmd(8'h11, 1, 9, "R8 ready clears status 0");

    // random scans
    for (int c = 0; c < 40; c++) begin
      secSize = SLOT_W'(3 + $urandom % 6);
      sendCmd(opList[$urandom % 3], 1, 9, "R1 random start");
      for (int s = 0; s < 3; s++) begin
        for (int i = 0; i < int'(secSize); i++) begin
          logic [7:0] h, d;
          h = 8'($urandom);
          d = ($urandom % 3 != 0) ? h : 8'($urandom);
          if ($urandom % 8 == 0) feed(i, d, h, 0, "R9 random stall");
          feed(i, d, h, 1, "R5 random byte");
        end
      end
      feed(0, 8'($urandom), 8'($urandom), 1'($urandom), "R7 random trailing");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule